// File: doc/BRIEF.md
# Operand-2 Shifter with Carry

This block forms the second ALU operand of a 32-bit load/store processor and the shifter carry that flag-setting logical and move operations consume. It is purely combinational. It reads the low twelve bits of the instruction word, an immediate-select bit, the current carry flag and two register-file read ports. It returns the operand and a carry-out.

When the immediate bit is set, an 8-bit constant is rotated right by an even amount. When it is clear, a source register is shifted by one of four shift kinds. The shift amount comes either from a 5-bit field in the instruction or from the low byte of a second register.

The block drives the register indices for both read ports from the instruction fields. The register file itself sits outside the block, and its read data returns on input ports.

Top module: `op2_shifter`

## Requirements
- R1: With `imm_sel`=1, `operand` equals `op_field[7:0]` zero-extended to 32 bits and rotated right by 2×`op_field[11:8]`.
- R2: With `imm_sel`=1, `carry_out` equals `carry_in` when `op_field[11:8]` is 0, and otherwise equals `operand[31]`.
- R3: `rm_idx` always equals `op_field[3:0]`, and `rs_idx` always equals `op_field[11:8]`.
- R4: With `imm_sel`=0, the shift amount is `rs_low` (0..255) when `op_field[4]`=1, and `op_field[11:7]` (0..31) when `op_field[4]`=0.
- R5: With `imm_sel`=0 and a shift amount of 0, `operand` equals `rm_data` and `carry_out` equals `carry_in`, whatever the shift kind.
- R6: Shift kind `op_field[6:5]`=00 is a logical left shift. For amounts 1..32 the carry is the last bit shifted out, that is `rm_data[32-n]`. For amounts above 32, both the operand and the carry are 0.
- R7: Shift kind 01 is a logical right shift. For amounts 1..32 the carry is `rm_data[n-1]`. For amounts above 32, both the operand and the carry are 0.
- R8: Shift kind 10 is an arithmetic right shift. For amounts 1..31 the carry is `rm_data[n-1]`. For amounts of 32 or more, the operand and the carry are all copies of `rm_data[31]`.
- R9: Shift kind 11 rotates right by the amount modulo 32. For any nonzero amount, `carry_out` equals `operand[31]`.
- R10: With `imm_sel`=1, the values on `rm_data` and `rs_low` have no effect on `operand` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field | input | 12 | Low twelve bits of the instruction word |
| imm_sel | input | 1 | Selects the rotated-constant path |
| carry_in | input | 1 | Current carry flag |
| rm_idx | output | 4 | Register index for the shifted source |
| rs_idx | output | 4 | Register index for the shift-amount register |
| rm_data | input | 32 | Read data for `rm_idx` |
| rs_low | input | 8 | Low byte of the read data for `rs_idx` |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry for the flag logic |

## Verification
The bench sweeps every register-held amount from 0 to 70, plus 255, across all four shift kinds. This exposes any design that stops at 31 or wraps its amount at 32. Such a design would give a nonzero operand or a stray carry at 33, or a wrong carry at exactly 32, where the carry must be the end bit of the source.

The bench also walks all 4096 immediate encodings with both carry values. A design that forgot to double the rotate field, or that ignored the rotate-of-zero carry rule, would fail there. Amount zero is exercised for every kind, to catch a rotate or left shift that clobbers the carry. Junk on the register ports while the immediate path is selected shows whether the output mux leaks.

// File: rtl/op2_shifter_pkg.sv
package op2_shifter_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e kind;
        logic        by_reg;
        logic [4:0]  imm_amt;
        logic [3:0]  rm_idx;
        logic [3:0]  rs_idx;
        logic [3:0]  rot;
        logic [7:0]  imm8;
    } shift_ctrl_t;

endpackage

// File: rtl/op2_field_decode.sv
module op2_field_decode
    import op2_shifter_pkg::*;
(
    input  logic [11:0] op_field,
    output shift_ctrl_t ctrl_d
);
    always_comb begin
        ctrl_d.kind    = shift_kind_e'(op_field[6:5]);
        ctrl_d.by_reg  = op_field[4];
        ctrl_d.imm_amt = op_field[11:7];
        ctrl_d.rm_idx  = op_field[3:0];
        ctrl_d.rs_idx  = op_field[11:8];
        ctrl_d.rot     = op_field[11:8];
        ctrl_d.imm8    = op_field[7:0];
    end
endmodule

// File: rtl/op2_imm_rotator.sv
module op2_imm_rotator #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value_d,
    output logic              carry_d
);
    localparam int RA_W = ROT_W + 1;

    logic [DATA_W-1:0]   zext;
    logic [RA_W-1:0]     rot_amt;
    logic [2*DATA_W-1:0] dbl;

    always_comb begin
        zext    = DATA_W'(imm);
        rot_amt = {rot, 1'b0};
        dbl     = {zext, zext} >> rot_amt;
        value_d = dbl[DATA_W-1:0];
        carry_d = (rot == '0) ? carry_in : dbl[DATA_W-1];
    end
endmodule

// File: rtl/op2_reg_shifter.sv
module op2_reg_shifter
    import op2_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amt,
    input  logic [DATA_W-1:0] src,
    input  logic              carry_in,
    output logic [DATA_W-1:0] value_d,
    output logic              carry_d
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W:0]     lsl_ext;
    logic [DATA_W:0]     lsr_ext;
    logic [DATA_W:0]     asr_ext;
    logic [2*DATA_W-1:0] ror_ext;

    always_comb begin
        // the extra bit in each extended vector catches the last bit shifted out
        lsl_ext = {1'b0, src} << amt;
        lsr_ext = {src, 1'b0} >> amt;
        asr_ext = $signed({src, 1'b0}) >>> amt;
        ror_ext = {src, src} >> amt[SH_W-1:0];

        unique case (kind)
            SH_LSL: begin
                value_d = lsl_ext[DATA_W-1:0];
                carry_d = lsl_ext[DATA_W];
            end
            SH_LSR: begin
                value_d = lsr_ext[DATA_W:1];
                carry_d = lsr_ext[0];
            end
            SH_ASR: begin
                value_d = asr_ext[DATA_W:1];
                carry_d = asr_ext[0];
            end
            default: begin
                value_d = ror_ext[DATA_W-1:0];
                carry_d = ror_ext[DATA_W-1];
            end
        endcase

        if (amt == '0) begin
            value_d = src;
            carry_d = carry_in;
        end
    end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
    import op2_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [11:0]       op_field,
    input  logic              imm_sel,
    input  logic              carry_in,
    output logic [3:0]        rm_idx,
    output logic [3:0]        rs_idx,
    input  logic [DATA_W-1:0] rm_data,
    input  logic [AMT_W-1:0]  rs_low,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out
);
    shift_ctrl_t       ctrl_d;
    logic [AMT_W-1:0]  amt_d;
    logic [DATA_W-1:0] imm_val_d;
    logic              imm_c_d;
    logic [DATA_W-1:0] reg_val_d;
    logic              reg_c_d;

    op2_field_decode u_dec (
        .op_field (op_field),
        .ctrl_d   (ctrl_d)
    );

    op2_imm_rotator #(.DATA_W(DATA_W), .IMM_W(8), .ROT_W(4)) u_imm (
        .imm      (ctrl_d.imm8),
        .rot      (ctrl_d.rot),
        .carry_in (carry_in),
        .value_d  (imm_val_d),
        .carry_d  (imm_c_d)
    );

    always_comb begin
        amt_d = ctrl_d.by_reg ? rs_low : AMT_W'(ctrl_d.imm_amt);
    end

    op2_reg_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_reg (
        .kind     (ctrl_d.kind),
        .amt      (amt_d),
        .src      (rm_data),
        .carry_in (carry_in),
        .value_d  (reg_val_d),
        .carry_d  (reg_c_d)
    );

    always_comb begin
        rm_idx    = ctrl_d.rm_idx;
        rs_idx    = ctrl_d.rs_idx;
        operand   = imm_sel ? imm_val_d : reg_val_d;
        carry_out = imm_sel ? imm_c_d   : reg_c_d;
    end
endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input logic [11:0]       op_field,
    input logic              imm_sel,
    input logic              carry_in,
    input logic [DATA_W-1:0] rm_data,
    input logic [AMT_W-1:0]  rs_low,
    input logic [DATA_W-1:0] operand,
    input logic              carry_out
);
    logic [AMT_W-1:0] amt_c;

    always_comb begin
        amt_c = op_field[4] ? rs_low : AMT_W'(op_field[11:7]);

        // R2
        imm_rot0_carry_chk: assert (!(imm_sel && op_field[11:8] == 4'd0)
            || (carry_out == carry_in && operand == DATA_W'(op_field[7:0])));
        // R2
        imm_rot_carry_chk: assert (!(imm_sel && op_field[11:8] != 4'd0)
            || carry_out == operand[DATA_W-1]);
        // R5
        zero_amt_pass_chk: assert (!(!imm_sel && amt_c == '0)
            || (operand == rm_data && carry_out == carry_in));
        // R9
        ror_carry_chk: assert (!(!imm_sel && op_field[6:5] == 2'b11 && amt_c != '0)
            || carry_out == operand[DATA_W-1]);
        // R6
        lsl_big_chk: assert (!(!imm_sel && op_field[6:5] == 2'b00 && amt_c > AMT_W'(DATA_W))
            || (operand == '0 && !carry_out));
        // R7
        lsr_big_chk: assert (!(!imm_sel && op_field[6:5] == 2'b01 && amt_c > AMT_W'(DATA_W))
            || (operand == '0 && !carry_out));
        // R8
        asr_big_chk: assert (!(!imm_sel && op_field[6:5] == 2'b10 && amt_c >= AMT_W'(DATA_W))
            || (operand == {DATA_W{rm_data[DATA_W-1]}} && carry_out == rm_data[DATA_W-1]));
    end
endmodule

bind op2_shifter op2_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .op_field  (op_field),
    .imm_sel   (imm_sel),
    .carry_in  (carry_in),
    .rm_data   (rm_data),
    .rs_low    (rs_low),
    .operand   (operand),
    .carry_out (carry_out)
);

// File: tb/tb_op2_shifter.sv
module tb_op2_shifter;
    logic        clk = 1'b0;
    logic [11:0] op_field = '0;
    logic        imm_sel = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] rm_data = '0;
    logic [7:0]  rs_low = '0;
    logic [3:0]  rm_idx, rs_idx;
    logic [31:0] operand;
    logic        carry_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    op2_shifter dut (
        .op_field (op_field), .imm_sel (imm_sel), .carry_in (carry_in),
        .rm_idx (rm_idx), .rs_idx (rs_idx), .rm_data (rm_data),
        .rs_low (rs_low), .operand (operand), .carry_out (carry_out)
    );

    // bit-serial reference, one position per loop step
    task automatic model(output logic [31:0] r, output logic c);
        int n;
        if (imm_sel) begin
            n = 2 * int'(op_field[11:8]);
            r = {24'd0, op_field[7:0]};
            for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
            c = (n == 0) ? carry_in : r[31];
        end else begin
            n = op_field[4] ? int'(rs_low) : int'(op_field[11:7]);
            r = rm_data;
            c = carry_in;
            for (int i = 0; i < n; i++) begin
                case (op_field[6:5])
                    2'b00: begin c = r[31]; r = {r[30:0], 1'b0}; end
                    2'b01: begin c = r[0];  r = {1'b0, r[31:1]}; end
                    2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
                    default: r = {r[0], r[31:1]};
                endcase
            end
            if (op_field[6:5] == 2'b11 && n != 0) c = r[31];
        end
    endtask

    task automatic apply_check(input logic [11:0] f, input logic is, input logic ci,
                               input logic [31:0] rm, input logic [7:0] rs, input string tag);
        logic [31:0] er;
        logic ec;
        @(posedge clk);
        op_field = f; imm_sel = is; carry_in = ci; rm_data = rm; rs_low = rs;
        @(negedge clk);
        model(er, ec);
        checks++;
        if (operand !== er || carry_out !== ec) begin
            errors++;
            $display("FAIL %s field=%h imm=%b cin=%b rm=%h rs=%h: got %h/%b expected %h/%b",
                     tag, f, is, ci, rm, rs, operand, carry_out, er, ec);
        end
        checks++;
        if (rm_idx !== f[3:0] || rs_idx !== f[11:8]) begin
            errors++;
            $display("FAIL R3 idx got %h/%h expected %h/%h", rm_idx, rs_idx, f[3:0], f[11:8]);
        end
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'b00: return "R6";
            2'b01: return "R7";
            2'b10: return "R8";
            default: return "R9";
        endcase
    endfunction

    logic [31:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                              32'h7FFF_FFFE, 32'hA5C3_3C5A, 32'h1234_8765};

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        #1;
        // reset-state (all-zero inputs): zero operand, carry follows carry_in
        apply_check(12'h000, 1'b0, 1'b0, 32'h0, 8'h0, "R5 idle");
        // R1 R2: every immediate encoding with both carry values
        for (int f = 0; f < 4096; f++)
            for (int ci = 0; ci < 2; ci++)
                apply_check(12'(f), 1'b1, 1'(ci), 32'h0, 8'h0, "R1/R2");
        // R10: junk on register ports must not reach the immediate result
        for (int k = 0; k < 64; k++)
            apply_check(12'($urandom), 1'b1, 1'($urandom), $urandom, 8'($urandom), "R10");
        // R4 R5 R6 R7 R8 R9: register-held amounts 0..70 and 255
        for (int t = 0; t < 4; t++)
            for (int a = 0; a <= 71; a++)
                for (int p = 0; p < 6; p++)
                    for (int ci = 0; ci < 2; ci++)
                        apply_check({4'($urandom), 1'b0, 2'(t), 1'b1, 4'($urandom)}, 1'b0,
                                    1'(ci), pats[p], (a == 71) ? 8'd255 : 8'(a),
                                    (a == 0) ? "R5 R4 reg" : kind_tag(2'(t)));
        // R4: instruction-field amounts 0..31
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 32; a++)
                for (int p = 0; p < 6; p++)
                    for (int ci = 0; ci < 2; ci++)
                        apply_check({5'(a), 2'(t), 1'b0, 4'($urandom)}, 1'b0, 1'(ci),
                                    pats[p], 8'($urandom), "R4 imm-amount");
        // random mix across both paths
        for (int k = 0; k < 3000; k++)
            apply_check(12'($urandom), 1'($urandom), 1'($urandom), $urandom,
                        8'($urandom), "R1 R4 R9 random");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule